// File: doc/BRIEF.md
# Latched Serial-to-Parallel Output Driver

This block turns a slow serial stream into an 8-bit parallel word held on output pins, as the front end of an LED or display driver. An external shift clock, a data line, a level-sensitive strobe and an active-low clear arrive as asynchronous pins. All four are brought into a fast system clock domain through two-flop synchronizers. A detected rising edge of the synchronized shift clock moves the captured data bit into the first stage of a shift register. The other bits move one stage along.

A holding stage sits between the shift register and the outputs. While the strobe is low it follows the shift register. While the strobe is high it freezes. While the clear pin is low it forces every output low. The clear acts on the holding stage only, so the shift register keeps its contents through a clear. The last stage of the shift register also drives a serial output, so several blocks can be chained.

Top module: `sipo_latch_driver`

## Requirements
- R1: While `rst_n` is low, and after it is released with no pin activity, `par_out` is 0 and `ser_out` is 0.
- R2: Each synchronized 0-to-1 transition of `sclk_pin` shifts the synchronized `sdata_pin` value into stage 0. Stage 0 drives `par_out[0]`. Stage k moves to stage k+1. A falling edge or a steady level causes no shift, so a bit sent first reaches `par_out[7]` after eight rising edges.
- R3: With `clear_n_pin` high and `strobe_pin` low, `par_out` equals the shift register contents no later than one system clock after the shift register changes.
- R4: While `strobe_pin` is high and `clear_n_pin` is high, `par_out` holds its value, even while shifts take place.
- R5: While `clear_n_pin` is low, `par_out` is 0 whatever the strobe, shift clock and data pins do.
- R6: A low `clear_n_pin` leaves the shift register unchanged, and shifting continues during a clear.
- R7: After `clear_n_pin` returns high, `par_out` stays 0 while the strobe is high. Once the strobe goes low, `par_out` takes the shift register contents.
- R8: `ser_out` equals the last shift stage, the bit that `par_out[7]` shows when the strobe is low.
- R9: A pin change made just after a system clock edge reaches the shift register at the third following rising edge. Under a low strobe it reaches `par_out` at the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| sclk_pin | input | 1 | External shift clock, asynchronous |
| sdata_pin | input | 1 | External serial data, asynchronous |
| strobe_pin | input | 1 | Low: outputs follow the shift register; high: hold |
| clear_n_pin | input | 1 | Active-low clear of the holding stage |
| par_out | output | WIDTH | Parallel outputs; bit 0 is the first stage |
| ser_out | output | 1 | Last shift stage, for cascading |

## Verification
The shift path is swept with every one of the 256 byte values, sent first-bit-last. Comparing the outputs after each single bit catches a wrong shift direction or a wrong stage order. A strobe-high pass shifts a new byte while the old one must stay visible, and the serial output shows the shift still happened. This separates holding from not shifting. Clear sequences under both strobe levels, followed by release with the strobe high and then low, show that the holding stage is cleared while the shift register survives. A latency probe samples a single edge two, three and four clocks later to pin down the synchronizer and register depth.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

    // Operating mode of the output holding stage
    typedef enum logic [1:0] {
        HOLD_CLEAR  = 2'd0,
        HOLD_FOLLOW = 2'd1,
        HOLD_KEEP   = 2'd2
    } hold_mode_e;

    // Lane positions inside the synchronizer bundle
    localparam int unsigned LANE_SCLK   = 0;
    localparam int unsigned LANE_SDATA  = 1;
    localparam int unsigned LANE_STROBE = 2;
    localparam int unsigned LANE_CLEARN = 3;
    localparam int unsigned LANE_COUNT  = 4;

endpackage

// File: rtl/sipo_pin_sync.sv
module sipo_pin_sync #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] din,
    output logic [LANES-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][LANES-1:0] stg;
    } sync_t;

    sync_t sync_d, sync_q;

    // Each stage takes the one before it; stage 0 takes the raw pins.
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_comb sync_d.stg[i] = din;
            end else begin : g_next
                always_comb sync_d.stg[i] = sync_q.stg[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign dout = sync_q.stg[STAGES-1];
endmodule

// File: rtl/sipo_shift_core.sv
module sipo_shift_core #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_s,
    input  logic             data_s,
    output logic [WIDTH-1:0] shreg,
    output logic             rise
);
    typedef struct packed {
        logic [WIDTH-1:0] sr;
        logic             sclk_prev;
    } core_t;

    core_t core_d, core_q;
    logic  rise_d;

    always_comb begin
        core_d           = core_q;
        rise_d           = sclk_s & ~core_q.sclk_prev;
        core_d.sclk_prev = sclk_s;
        if (rise_d) begin
            core_d.sr = {core_q.sr[WIDTH-2:0], data_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign shreg = core_q.sr;
    assign rise  = rise_d;
endmodule

// File: rtl/sipo_hold_stage.sv
module sipo_hold_stage
    import sipo_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] shreg,
    input  logic             strobe_s,
    input  logic             clear_s,
    output logic [WIDTH-1:0] par_out
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
    } hold_t;

    hold_t      hold_d, hold_q;
    hold_mode_e mode;

    always_comb begin
        // Clear wins over the strobe.
        if (!clear_s) begin
            mode = HOLD_CLEAR;
        end else if (!strobe_s) begin
            mode = HOLD_FOLLOW;
        end else begin
            mode = HOLD_KEEP;
        end

        hold_d = hold_q;
        unique case (mode)
            HOLD_CLEAR:  hold_d.word = '0;
            HOLD_FOLLOW: hold_d.word = shreg;
            default:     hold_d.word = hold_q.word;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign par_out = hold_q.word;
endmodule

// File: rtl/sipo_latch_driver.sv
module sipo_latch_driver
    import sipo_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_pin,
    input  logic             sdata_pin,
    input  logic             strobe_pin,
    input  logic             clear_n_pin,
    output logic [WIDTH-1:0] par_out,
    output logic             ser_out
);
    logic [LANE_COUNT-1:0] pins_raw;
    logic [LANE_COUNT-1:0] pins_s;
    logic                  sclk_s;
    logic                  data_s;
    logic                  strobe_s;
    logic                  clear_s;
    logic [WIDTH-1:0]      shreg;
    logic                  rise;

    always_comb begin
        pins_raw              = '0;
        pins_raw[LANE_SCLK]   = sclk_pin;
        pins_raw[LANE_SDATA]  = sdata_pin;
        pins_raw[LANE_STROBE] = strobe_pin;
        pins_raw[LANE_CLEARN] = clear_n_pin;
    end

    sipo_pin_sync #(
        .LANES  (LANE_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_raw),
        .dout  (pins_s)
    );

    assign sclk_s   = pins_s[LANE_SCLK];
    assign data_s   = pins_s[LANE_SDATA];
    assign strobe_s = pins_s[LANE_STROBE];
    assign clear_s  = pins_s[LANE_CLEARN];

    sipo_shift_core #(
        .WIDTH (WIDTH)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (sclk_s),
        .data_s (data_s),
        .shreg  (shreg),
        .rise   (rise)
    );

    sipo_hold_stage #(
        .WIDTH (WIDTH)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .shreg    (shreg),
        .strobe_s (strobe_s),
        .clear_s  (clear_s),
        .par_out  (par_out)
    );

    assign ser_out = shreg[WIDTH-1];
endmodule

// File: rtl/sipo_latch_driver_chk.sv
module sipo_latch_driver_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rise,
    input logic             data_s,
    input logic             strobe_s,
    input logic             clear_s,
    input logic [WIDTH-1:0] shreg,
    input logic [WIDTH-1:0] par_out
);
    // R2: a detected rising edge moves the register by one stage
    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> shreg == {$past(shreg[WIDTH-2:0]), $past(data_s)});

    // R2: no rising edge, no change
    p_no_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(shreg));

    // R3: transparent path
    p_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_s && !strobe_s) |=> par_out == $past(shreg));

    // R4: strobe high freezes the outputs
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_s && strobe_s) |=> $stable(par_out));

    // R5: clear forces zero
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_s |=> par_out == '0);

    // R6: clear leaves the shift register alone
    p_clear_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_s && !rise) |=> $stable(shreg));
endmodule

bind sipo_latch_driver sipo_latch_driver_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (rise),
    .data_s   (data_s),
    .strobe_s (strobe_s),
    .clear_s  (clear_s),
    .shreg    (shreg),
    .par_out  (par_out)
);

// File: tb/sipo_latch_driver_test.sv
module sipo_latch_driver_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_pin = 1'b0;
    logic       sdata_pin = 1'b0;
    logic       strobe_pin = 1'b0;
    logic       clear_n_pin = 1'b1;
    logic [7:0] par_out;
    logic       ser_out;

    int         n_checks = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;
    logic [7:0] model = 8'h00;

    always #4 clk = ~clk;

    sipo_latch_driver uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_pin    (sclk_pin),
        .sdata_pin   (sdata_pin),
        .strobe_pin  (strobe_pin),
        .clear_n_pin (clear_n_pin),
        .par_out     (par_out),
        .ser_out     (ser_out)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One full serial clock cycle; all effects settled on return.
    task automatic send_bit(input logic b);
        @(negedge clk);
        sdata_pin = b;
        idle(3);
        sclk_pin = 1'b1;
        idle(5);
        sclk_pin = 1'b0;
        idle(5);
        model = {model[6:0], b};
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    initial begin
        idle(3);
        check8("R1 par_out in reset", par_out, 8'h00);
        check8("R1 ser_out in reset", {7'd0, ser_out}, 8'h00);
        rst_n = 1'b1;
        idle(6);
        check8("R1 par_out after reset", par_out, 8'h00);

        // R2 R3 R8: every byte, checked after every bit
        for (int v = 0; v < 256; v++) begin
            for (int i = 7; i >= 0; i--) begin
                send_bit(v[i]);
                check8("R2 R3 par_out per bit", par_out, model);
            end
            check8("R2 full byte at outputs", par_out, v[7:0]);
            check8("R8 ser_out last stage", {7'd0, ser_out}, {7'd0, model[7]});
        end

        // R9 latency: from 0x40 one more 0 gives 0x80
        send_byte(8'h40);
        @(negedge clk);
        sdata_pin = 1'b0;
        @(negedge clk);
        sclk_pin = 1'b1;
        idle(2);
        check8("R9 par_out unchanged after 2", par_out, 8'h40);
        check8("R9 ser_out unchanged after 2", {7'd0, ser_out}, 8'h00);
        idle(1);
        check8("R9 ser_out new after 3", {7'd0, ser_out}, 8'h01);
        check8("R9 par_out old after 3", par_out, 8'h40);
        idle(1);
        check8("R9 R3 par_out new after 4", par_out, 8'h80);
        sclk_pin = 1'b0;
        idle(5);
        model = 8'h80;

        // R4: hold while shifting
        send_byte(8'hA5);
        strobe_pin = 1'b1;
        idle(4);
        send_byte(8'h3C);
        check8("R4 outputs held", par_out, 8'hA5);
        check8("R4 R8 shift continued", {7'd0, ser_out}, 8'h00);
        strobe_pin = 1'b0;
        idle(5);
        check8("R3 strobe low shows new", par_out, 8'h3C);

        // R5 R6: clear with strobe low, shift during clear
        clear_n_pin = 1'b0;
        idle(5);
        check8("R5 clear forces zero", par_out, 8'h00);
        send_byte(8'hC3);
        check8("R5 clear holds zero while shifting", par_out, 8'h00);
        check8("R6 shift during clear", {7'd0, ser_out}, 8'h01);
        // R7: release with strobe high
        strobe_pin = 1'b1;
        idle(5);
        clear_n_pin = 1'b1;
        idle(6);
        check8("R7 stays zero after release", par_out, 8'h00);
        strobe_pin = 1'b0;
        idle(5);
        check8("R6 R7 register survived clear", par_out, 8'hC3);

        // R5 with strobe high, R6 no shift during clear
        strobe_pin = 1'b1;
        idle(4);
        clear_n_pin = 1'b0;
        idle(5);
        check8("R5 clear under strobe high", par_out, 8'h00);
        clear_n_pin = 1'b1;
        idle(5);
        check8("R7 zero until strobe low", par_out, 8'h00);
        strobe_pin = 1'b0;
        idle(5);
        check8("R6 register untouched", par_out, 8'hC3);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule